// File: doc/BRIEF.md
# Pipelined burst SRAM access core

This block is a synchronous single-port static memory with the control front end of a pipelined burst part. Each word is 18 bits wide and is split into two 9-bit byte lanes. A cycle begins when one of two address strobes is sampled low: a processor-side strobe or a controller-side strobe. Three chip-enable inputs qualify the start. A started cycle loads a base address. A 2-bit wrapping burst counter then walks the low two address bits, either in XOR-interleaved order or in linear wrap-around order. The upper address bits stay fixed for the whole burst.

Writes take one clock and are qualified by a global write input, a byte-write enable and one select per lane. Reads are pipelined: the word at a registered address appears on the output one clock later. The data bus is split into `dq_in`, `dq_out` and an output-enable `dq_oe`, which the pad ring combines into one shared bus. The output is released whenever the write inputs request a write, whatever the level of `oe_n`.

The cycle tracker has three named states. `ST_IDLE` means no access is in progress. `ST_READ` means the last registered cycle was a read. `ST_WRITE` means the last registered cycle was a write. The transitions are as follows:
- DESELECT: any state goes to `ST_IDLE` when a strobe is sampled and an enable is inactive.
- START_RD: any state goes to `ST_READ` on an enabled processor-strobe start, or on a controller-strobe start that has no write request.
- START_WR: any state goes to `ST_WRITE` on an enabled controller-strobe start that has a write request.
- CONT_RD: `ST_READ` or `ST_WRITE` goes to `ST_READ` when no strobe is sampled and no write is requested.
- CONT_WR: `ST_READ` or `ST_WRITE` goes to `ST_WRITE` when no strobe is sampled and a write is requested.
- HOLD_IDLE: `ST_IDLE` stays in `ST_IDLE` when no strobe is sampled.

Top module: `sync_burst_sram`

## Requirements
- R1: When `gw_n` is 0 during a write cycle, both lanes of the addressed word are written, whatever `bwe_n` and `bw_n` are.
- R2: When `gw_n` is 1 and `bwe_n` is 0, only the lanes whose `bw_n` bit is 0 are written, and the other lane keeps its old value. Bit 0 selects lane A (`dq_in[8:0]`) and bit 1 selects lane B (`dq_in[17:9]`).
- R3: A cycle with `adsc_n`=0, `adsp_n`=1, all enables active (`ce1_n`=0, `ce2`=1, `ce3_n`=0) and a write request writes `dq_in` at address `addr` on that same clock edge.
- R4: On any enabled start, the address is loaded from `addr` and `adv_n` has no effect in that cycle.
- R5: `dq_oe` is 0 in any cycle in which the write inputs request a write (`gw_n`=0, or `bwe_n`=0 with any `bw_n` bit 0), whatever the level of `oe_n`.
- R6: With `mode`=1, the beats of a burst use the low address bits start XOR 0, 1, 2 and 3 in turn.
- R7: With `mode`=0, the beats of a burst use the low address bits start+0, +1, +2 and +3, each taken modulo 4.
- R8: In a cycle with no strobe, `adv_n`=0 at the clock edge steps the burst to its next address. `adv_n`=1 repeats the current address.
- R9: The burst wraps after four steps, so a fifth beat returns to the start address. The upper address bits never change during a burst.
- R10: A strobe sampled with any enable inactive writes nothing and forces `dq_oe` to 0 in the following cycle.
- R11: Read data for a registered address appears on `dq_out` with `dq_oe`=1 one clock later, and only while `oe_n` is 0.
- R12: When `adsp_n` is 0, the processor strobe takes priority over `adsc_n`, and the start cycle is a read that ignores the write inputs.
- R13: While `rst_n` is 0, `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane write selects, active low (bit 0 is lane A) |
| adv_n | input | 1 | Burst advance, active low |
| mode | input | 1 | Burst order: 1 is interleaved, 0 is linear |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 18 | Write data |
| dq_out | output | 18 | Read data |
| dq_oe | output | 1 | Output driver enable for the shared bus |

## Verification
If the burst counter or its seed is corrupted, the wrong word appears on `dq_out` one clock after the bad beat is registered. The scoreboard's next pop then reports it. An error in the cycle tracker shows up differently. A state wrongly left in `ST_READ` raises `dq_oe` after a deselect, with no data expected. A state wrongly left in `ST_IDLE` drops data that the bench expects, and the queue is left non-empty at the end. Lane-decode faults stay hidden until the affected word is read back, which happens within a few cycles of each write sequence.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cyc_state_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              mode,
    input  logic [STEP_W-1:0] seed,
    output logic [STEP_W-1:0] cur_low,
    output logic [STEP_W-1:0] nxt_low,
    output logic [STEP_W-1:0] step_cnt
);
    logic [STEP_W-1:0] seed_q;
    logic [STEP_W-1:0] cnt_q;
    logic [STEP_W-1:0] cnt_inc;

    assign cnt_inc  = cnt_q + STEP_W'(1);
    assign step_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            seed_q <= seed;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_inc;
        end
    end

    always_comb begin
        if (mode) begin
            cur_low = seed_q ^ cnt_q;
            nxt_low = seed_q ^ cnt_inc;
        end else begin
            cur_low = seed_q + cnt_q;
            nxt_low = seed_q + cnt_inc;
        end
    end
endmodule

// File: rtl/lane_wr_dec.sv
module lane_wr_dec #(
    parameter int LANES = 2
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_mask,
    output logic             wr_req
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g] = !gw_n || (!bwe_n && !bw_n[g]);
    end

    assign wr_req = |lane_mask;
endmodule

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
    import sram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adsp_n,
    input  logic       adsc_n,
    input  logic       en_ok,
    input  logic       wr_req,
    input  logic       adv_n,
    output cyc_state_e state,
    output logic       load,
    output logic       step,
    output logic       wr_now,
    output logic       rd_issue
);
    cyc_state_e state_q;
    cyc_state_e state_d;
    logic       start_p;
    logic       start_c;
    logic       start;
    logic       busy;

    assign start_p = !adsp_n;
    assign start_c = adsp_n && !adsc_n;
    assign start   = start_p || start_c;
    assign busy    = (state_q != ST_IDLE);
    assign state   = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            if (!en_ok)                  state_d = ST_IDLE;
            else if (start_c && wr_req)  state_d = ST_WRITE;
            else                         state_d = ST_READ;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_READ:  state_d = wr_req ? ST_WRITE : ST_READ;
                ST_WRITE: state_d = wr_req ? ST_WRITE : ST_READ;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load     = start && en_ok;
        step     = !start && busy && !adv_n;
        wr_now   = (start_c && en_ok && wr_req) || (!start && busy && wr_req);
        rd_issue = (state_q == ST_READ) && !(start && !en_ok);
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_lane,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    re,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lane[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (re) rdata[g*LANE_W +: LANE_W] <= mem[raddr];
        end
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [1:0]        bw_n,
    input  logic              adv_n,
    input  logic              mode,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [17:0]       dq_in,
    output logic [17:0]       dq_out,
    output logic              dq_oe
);
    localparam int STEP_W = 2;
    localparam int HI_W   = ADDR_W - STEP_W;

    cyc_state_e         cyc_state;
    logic               en_ok;
    logic               wr_req;
    logic [LANES-1:0]   lane_mask;
    logic               load;
    logic               step;
    logic               wr_now;
    logic               rd_issue;
    logic [STEP_W-1:0]  cur_low;
    logic [STEP_W-1:0]  nxt_low;
    logic [STEP_W-1:0]  burst_step;
    logic [HI_W-1:0]    hi_q;
    logic [ADDR_W-1:0]  cur_addr;
    logic [ADDR_W-1:0]  wr_addr;
    logic               rd_vld_q;

    assign en_ok = !ce1_n && ce2 && !ce3_n;

    lane_wr_dec #(.LANES(LANES)) u_dec (
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .lane_mask (lane_mask),
        .wr_req    (wr_req)
    );

    cyc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .en_ok    (en_ok),
        .wr_req   (wr_req),
        .adv_n    (adv_n),
        .state    (cyc_state),
        .load     (load),
        .step     (step),
        .wr_now   (wr_now),
        .rd_issue (rd_issue)
    );

    burst_seq #(.STEP_W(STEP_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .mode     (mode),
        .seed     (addr[STEP_W-1:0]),
        .cur_low  (cur_low),
        .nxt_low  (nxt_low),
        .step_cnt (burst_step)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            rd_vld_q <= 1'b0;
        end else begin
            if (load) hi_q <= addr[ADDR_W-1:STEP_W];
            rd_vld_q <= rd_issue;
        end
    end

    assign cur_addr = {hi_q, cur_low};

    always_comb begin
        if (load)      wr_addr = addr;
        else if (step) wr_addr = {hi_q, nxt_low};
        else           wr_addr = cur_addr;
    end

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .we_lane (wr_now ? lane_mask : '0),
        .waddr   (wr_addr),
        .wdata   (dq_in),
        .re      (rd_issue),
        .raddr   (cur_addr),
        .rdata   (dq_out)
    );

    assign dq_oe = rd_vld_q && !oe_n && !wr_req;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk
    import sram_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       adsp_n,
    input logic       adsc_n,
    input logic       ce1_n,
    input logic       ce2,
    input logic       ce3_n,
    input logic       gw_n,
    input logic       bwe_n,
    input logic [1:0] bw_n,
    input logic       adv_n,
    input logic       oe_n,
    input logic [1:0] addr_lo,
    input logic       dq_oe,
    input cyc_state_e cyc_state,
    input logic [1:0] cur_low,
    input logic [1:0] burst_step
);
    logic strobe;
    logic enabled;
    logic wr_in;

    assign strobe  = !adsp_n || !adsc_n;
    assign enabled = !ce1_n && ce2 && !ce3_n;
    assign wr_in   = !gw_n || (!bwe_n && (bw_n != 2'b11));

    assert_hiz_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in |-> !dq_oe);

    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_n);

    assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !enabled) |=> !dq_oe);

    assert_load_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && enabled) |=> (cur_low == $past(addr_lo) && burst_step == 2'd0));

    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && cyc_state != ST_IDLE && !adv_n) |=> (burst_step == $past(burst_step) + 2'd1));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && adv_n) |=> $stable(burst_step));

    assert_adsp_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && enabled) |=> (cyc_state == ST_READ));

    always_comb begin
        if (!rst_n) assert_reset_quiet_R13: assert (!dq_oe);
    end
endmodule

bind sync_burst_sram sync_burst_sram_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .adsp_n     (adsp_n),
    .adsc_n     (adsc_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .bw_n       (bw_n),
    .adv_n      (adv_n),
    .oe_n       (oe_n),
    .addr_lo    (addr[1:0]),
    .dq_oe      (dq_oe),
    .cyc_state  (cyc_state),
    .cur_low    (cur_low),
    .burst_step (burst_step)
);

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          adsp_n, adsc_n, ce1_n, ce2, ce3_n;
    logic          gw_n, bwe_n, adv_n, mode, oe_n;
    logic [1:0]    bw_n;
    logic [AW-1:0] addr;
    logic [17:0]   dq_in;
    logic [17:0]   dq_out;
    logic          dq_oe;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    logic [17:0] mdl [0:(1<<AW)-1];
    logic [17:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .adv_n(adv_n), .mode(mode), .oe_n(oe_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] a, int idx, bit md);
        logic [1:0] lo;
        lo = md ? (a[1:0] ^ 2'(idx)) : (a[1:0] + 2'(idx));
        return {a[AW-1:2], lo};
    endfunction

    task automatic check(string req, logic [17:0] act, logic [17:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        adsp_n = 1; adsc_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = 2'b11; adv_n = 1; dq_in = '0;
    endtask

    task automatic deselect();
        @(negedge clk);
        quiet_inputs();
        adsc_n = 0; ce1_n = 1;
    endtask

    // Monitor: pops one expected word per cycle with dq_oe high
    always @(posedge clk) begin
        #5;
        if (rst_n === 1'b1 && dq_oe === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R10/R11 unexpected drive", {17'd0, dq_oe}, 18'd0);
            end else begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, dq_out, e);
            end
        end
    end

    task automatic write_burst(logic [AW-1:0] a, int n, bit md, logic [17:0] d0,
                               logic g, logic be, logic [1:0] bw, string req);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] wa;
            logic [17:0]   d;
            @(negedge clk);
            quiet_inputs();
            mode = md; oe_n = 0; adv_n = 0;     // adv ignored on start beat (R4)
            gw_n = g; bwe_n = be; bw_n = bw;
            if (i == 0) begin adsc_n = 0; addr = a; end
            d = d0 + 18'(i * 7);
            dq_in = d;
            wa = beat_addr(a, i, md);
            if (!g || (!be && !bw[0])) mdl[wa][8:0]  = d[8:0];
            if (!g || (!be && !bw[1])) mdl[wa][17:9] = d[17:9];
            #1 check({req, " R5 hiz during write"}, {17'd0, dq_oe}, 18'd0);
        end
        deselect();
    endtask

    task automatic read_burst(logic [AW-1:0] a, int n, bit md, bit use_adsp,
                              bit oe_hi, logic [7:0] susp, bit gw_first, string req);
        int idx = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            quiet_inputs();
            mode = md; oe_n = oe_hi;
            if (i == 0) begin
                addr = a; adv_n = 0;
                if (use_adsp) begin adsp_n = 0; adsc_n = 0; end
                else adsc_n = 0;
                if (gw_first) gw_n = 0;
            end else begin
                adv_n = susp[i];
                if (!susp[i]) idx++;
            end
            if (!oe_hi) begin
                exp_q.push_back(mdl[beat_addr(a, idx, md)]);
                tag_q.push_back(req);
            end
        end
        @(negedge clk);                          // hold cycle: last beat's data out
        quiet_inputs();
        mode = md; oe_n = oe_hi;
        #1 if (oe_hi) check("R11 no drive while oe_n high", {17'd0, dq_oe}, 18'd0);
        deselect();
        oe_n = oe_hi;
        @(posedge clk); #5;
        check("R10 released after deselect", {17'd0, dq_oe}, 18'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < (1 << AW); k++) mdl[k] = 18'h0;
        quiet_inputs();
        mode = 1; oe_n = 0; addr = '0; rst_n = 0;
        repeat (3) @(posedge clk);
        #5 check("R13 reset quiet", {17'd0, dq_oe}, 18'd0);
        // Clear the test region so the model and array agree
        write_burst(10'h010, 4, 1, 18'h00000, 0, 1, 2'b11, "R1");
        @(negedge clk); rst_n = 1;
        write_burst(10'h010, 4, 1, 18'h00000, 0, 1, 2'b11, "R1");
        write_burst(10'h020, 4, 1, 18'h00000, 0, 1, 2'b11, "R1");
        write_burst(10'h030, 4, 1, 18'h00000, 0, 1, 2'b11, "R1");

        // R1/R3: global write burst, interleaved from seed 00
        write_burst(10'h010, 4, 1, 18'h1A2B3, 0, 1, 2'b11, "R3");
        // R6: interleaved read from seed 01 -> 01,00,11,10
        read_burst(10'h011, 4, 1, 0, 0, 8'h00, 0, "R6 interleaved");
        // R7: linear write and read from seed 10 -> 10,11,00,01
        write_burst(10'h022, 4, 0, 18'h05050, 0, 1, 2'b11, "R7");
        read_burst(10'h022, 4, 0, 0, 0, 8'h00, 0, "R7 linear");
        // R9: fifth beat wraps back to seed
        read_burst(10'h023, 5, 0, 0, 0, 8'h00, 0, "R9 wrap");
        read_burst(10'h013, 5, 1, 0, 0, 8'h00, 0, "R9 wrap interleaved");
        // R2: byte writes; lane A only then lane B only
        write_burst(10'h011, 1, 1, 18'h3FFFF, 1, 0, 2'b10, "R2");
        write_burst(10'h012, 1, 1, 18'h2AAAA, 1, 0, 2'b01, "R2");
        read_burst(10'h011, 2, 0, 0, 0, 8'h00, 0, "R2 lane select");
        // R1: gw priority over cleared lane selects
        write_burst(10'h013, 1, 1, 18'h15555, 0, 0, 2'b11, "R1");
        read_burst(10'h013, 1, 1, 0, 0, 8'h00, 0, "R1 global write");
        // R8: suspend on beat 1 and beat 3
        read_burst(10'h010, 5, 1, 0, 0, 8'h0A, 0, "R8 advance/suspend");
        // R12: processor strobe wins, write inputs ignored on start
        read_burst(10'h022, 2, 0, 1, 0, 8'h00, 1, "R12 adsp read");
        // R11: oe_n high gives no drive
        read_burst(10'h020, 3, 1, 0, 1, 8'h00, 0, "R11");

        // R5: write right after a read start, read data pending
        @(negedge clk); quiet_inputs(); mode = 1; oe_n = 0; adsp_n = 0; addr = 10'h030;
        @(negedge clk); quiet_inputs(); mode = 1; oe_n = 0; adsc_n = 0; addr = 10'h030;
        gw_n = 0; dq_in = 18'h0BEEF; mdl[10'h030] = 18'h0BEEF;
        #1 check("R5 hiz on write start", {17'd0, dq_oe}, 18'd0);
        @(negedge clk); quiet_inputs(); mode = 1; oe_n = 0; adv_n = 0;
        gw_n = 0; dq_in = 18'h0CAFE; mdl[10'h031] = 18'h0CAFE;
        #1 check("R5 hiz with read pending", {17'd0, dq_oe}, 18'd0);
        deselect();
        read_burst(10'h030, 2, 1, 0, 0, 8'h00, 0, "R5 write landed");

        // R10: strobe with ce2 low and a write request does nothing
        @(negedge clk); quiet_inputs(); oe_n = 0; adsc_n = 0; ce2 = 0;
        addr = 10'h010; gw_n = 0; dq_in = 18'h3DEAD;
        @(negedge clk); quiet_inputs();
        read_burst(10'h010, 1, 1, 0, 0, 8'h00, 0, "R10 no write when deselected");

        // R4: adv_n low on the start beat; start address still used
        read_burst(10'h012, 1, 1, 0, 0, 8'h00, 0, "R4 adv ignored on start");

        repeat (4) @(posedge clk);
        check("R11 all expected reads seen", 18'(exp_q.size()), 18'd0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule